// File: doc/BRIEF.md
# Dual-Half Count-Up Timer with Compare Bank

This peripheral holds two independent 32-bit count-up counters, a low half and a high half, behind a small word-addressed register bus. Each half has its own counter, period and run mode. A half can stay stopped, fire once, or repeat. When its counter reaches the period value the half raises a one-cycle interrupt and restarts from zero. In single-shot mode the half also returns its own mode field to stopped.

A global control word selects the unchained two-counter arrangement and releases each half from reset on its own. A half that is not released stays at zero and ignores counter writes. The low half also has eight compare registers. While the low counter runs, a match against any of them raises a separate one-cycle compare interrupt. A match never reloads or stops the counter. Software uses this to schedule events against a free-running time base.

Top module: `cnt_pair_timer`

## Requirements
- R1: After synchronous reset every register reads zero and all three interrupt outputs are low.
- R2: Registers sit at word offsets: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, run control 0x20, global control 0x24, compare entry i at 0x60+4*i (i = 0..7). Run control keeps only bits [7:6] (low mode) and [23:22] (high mode); global control keeps bits [3:0]. Other bits and unmapped offsets read zero.
- R3: In repeat mode (field value 2'b10) a half with period P drives its interrupt high for exactly one cycle after its counter holds P, and the counter restarts at 0. Pulses are therefore P+1 cycles apart.
- R4: In single-shot mode (field value 2'b01) the half pulses its interrupt once when the counter reaches the period. Its mode field then reads 2'b00 and its counter reads 0 and stays there.
- R5: A half counts only when global control bits [3:2] equal 2'b01 and its release bit is 1 (bit 0 low, bit 1 high). Otherwise its counter is held at 0, counter writes are ignored and its interrupt stays low.
- R6: A running counter increments by one per cycle and wraps from 0xFFFFFFFF to 0 when the period is not reached first.
- R7: A bus write to a counter offset loads that counter directly, taking priority over counting and reload.
- R8: The compare interrupt pulses one cycle after the running low counter equals any compare entry. The low counter continues incrementing without reload.
- R9: With a mode field of 2'b00 or 2'b11 a released half holds its counter value and raises no interrupt; the compare interrupt also stays low while the low half is not counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_lo | output | 1 | Low-half period interrupt pulse |
| irq_hi | output | 1 | High-half period interrupt pulse |
| irq_cmp | output | 1 | Compare-match interrupt pulse |

## Verification
Repeat mode is swept over periods 0 through 6 on both halves, including the degenerate period 0 that fires every cycle. Interrupt spacing and the counter value are checked every cycle, which separates an off-by-one in the reload from a missed match. Single-shot runs confirm that one pulse is followed by silence and a cleared mode field. A start just below the 32-bit limit exposes the wrap. Each of the eight compare entries is tried alone with a distinct target, which tells apart a wrong entry select, a late pulse and a counter that wrongly reloads on a match. The global-control patterns with a wrong timer mode or an unreleased half show that the hold gates counting, counter writes and interrupts alike.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int AW = 8;

    // Register offsets
    localparam logic [AW-1:0] A_CNT_LO   = 8'h10;
    localparam logic [AW-1:0] A_CNT_HI   = 8'h14;
    localparam logic [AW-1:0] A_PRD_LO   = 8'h18;
    localparam logic [AW-1:0] A_PRD_HI   = 8'h1C;
    localparam logic [AW-1:0] A_RUNCTL   = 8'h20;
    localparam logic [AW-1:0] A_GLBCTL   = 8'h24;
    localparam logic [AW-1:0] A_CMP_BASE = 8'h60;

    // Run-control field positions (decoded per half)
    localparam int RC_LO_SH = 6;
    localparam int RC_HI_SH = 22;

    // Global control layout
    localparam int GC_W       = 4;
    localparam int GC_TM_LSB  = 2;
    localparam logic [1:0] TM_UNCHAINED = 2'b01;

    typedef enum logic [1:0] {
        EM_OFF  = 2'b00,
        EM_ONCE = 2'b01,
        EM_LOOP = 2'b10,
        EM_RSVD = 2'b11
    } en_mode_e;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic prd_lo;
        logic prd_hi;
        logic runctl;
        logic glbctl;
    } wr_stb_t;

    function automatic logic [AW-1:0] cmp_addr(input int idx);
        return A_CMP_BASE + AW'(idx * 4);
    endfunction

    function automatic logic mode_counts(input logic [1:0] m);
        return (m == EM_ONCE) || (m == EM_LOOP);
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    output wr_stb_t       stb_o,
    output logic [N-1:0]  cmp_sel_o
);

    always_comb begin
        stb_o        = '0;
        stb_o.cnt_lo = we_i && (addr_i == A_CNT_LO);
        stb_o.cnt_hi = we_i && (addr_i == A_CNT_HI);
        stb_o.prd_lo = we_i && (addr_i == A_PRD_LO);
        stb_o.prd_hi = we_i && (addr_i == A_PRD_HI);
        stb_o.runctl = we_i && (addr_i == A_RUNCTL);
        stb_o.glbctl = we_i && (addr_i == A_GLBCTL);
        for (int i = 0; i < N; i++) begin
            cmp_sel_o[i] = we_i && (addr_i == cmp_addr(i));
        end
    end

endmodule

// File: rtl/tmr_half.sv
module tmr_half
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          cnt_we_i,
    input  logic          prd_we_i,
    input  logic          mode_we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [1:0]    mode_wdata_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] prd_o,
    output logic [1:0]    mode_o,
    output logic          counting_o,
    output logic          irq_o
);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] prd_q;
    en_mode_e      mode_q;
    logic          irq_q;
    logic          counting;
    logic          hit;

    assign counting = run_i && mode_counts(mode_q);
    assign hit      = counting && (cnt_q == prd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prd_q  <= '0;
            mode_q <= EM_OFF;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= hit;

            if (prd_we_i) begin
                prd_q <= wdata_i;
            end

            if (!run_i) begin
                cnt_q <= '0;
            end else if (cnt_we_i) begin
                cnt_q <= wdata_i;
            end else if (hit) begin
                cnt_q <= '0;
            end else if (counting) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (mode_we_i) begin
                mode_q <= en_mode_e'(mode_wdata_i);
            end else if (hit && (mode_q == EM_ONCE)) begin
                mode_q <= EM_OFF;
            end
        end
    end

    assign cnt_o      = cnt_q;
    assign prd_o      = prd_q;
    assign mode_o     = mode_q;
    assign counting_o = counting;
    assign irq_o      = irq_q;

endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
    parameter int DW = 32,
    parameter int N  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  wr_sel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] cnt_i,
    input  logic          active_i,
    output logic [DW-1:0] val_o [N],
    output logic          irq_o
);

    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                val_o[i] <= '0;
            end else if (wr_sel_i[i]) begin
                val_o[i] <= wdata_i;
            end
        end
        assign eq[i] = (val_o[i] == cnt_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= active_i && (|eq);
        end
    end

endmodule

// File: rtl/cnt_pair_timer.sv
module cnt_pair_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_CMP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_cmp
);

    localparam int NHALF = 2;

    wr_stb_t              stb;
    logic [NUM_CMP-1:0]   cmp_sel;
    logic [GC_W-1:0]      gctrl_q;
    logic                 tm_ok;
    logic [NHALF-1:0]     run_v;
    logic [NHALF-1:0]     counting_v;
    logic [NHALF-1:0]     irq_v;
    logic [DATA_W-1:0]    cnt_v  [NHALF];
    logic [DATA_W-1:0]    prd_v  [NHALF];
    logic [1:0]           mode_v [NHALF];
    logic [DATA_W-1:0]    cmp_val [NUM_CMP];

    tmr_decode #(.N(NUM_CMP)) u_dec (
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .stb_o     (stb),
        .cmp_sel_o (cmp_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gctrl_q <= '0;
        end else if (stb.glbctl) begin
            gctrl_q <= bus_wdata[GC_W-1:0];
        end
    end

    assign tm_ok = (gctrl_q[GC_TM_LSB +: 2] == TM_UNCHAINED);

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam int SH = (h == 0) ? RC_LO_SH : RC_HI_SH;
        assign run_v[h] = tm_ok && gctrl_q[h];
        tmr_half #(.DW(DATA_W)) u_half (
            .clk          (clk),
            .rst          (rst),
            .run_i        (run_v[h]),
            .cnt_we_i     ((h == 0) ? stb.cnt_lo : stb.cnt_hi),
            .prd_we_i     ((h == 0) ? stb.prd_lo : stb.prd_hi),
            .mode_we_i    (stb.runctl),
            .wdata_i      (bus_wdata),
            .mode_wdata_i (bus_wdata[SH +: 2]),
            .cnt_o        (cnt_v[h]),
            .prd_o        (prd_v[h]),
            .mode_o       (mode_v[h]),
            .counting_o   (counting_v[h]),
            .irq_o        (irq_v[h])
        );
    end

    tmr_cmp_bank #(.DW(DATA_W), .N(NUM_CMP)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .wr_sel_i (cmp_sel),
        .wdata_i  (bus_wdata),
        .cnt_i    (cnt_v[0]),
        .active_i (counting_v[0]),
        .val_o    (cmp_val),
        .irq_o    (irq_cmp)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt_v[0];
            A_CNT_HI: bus_rdata = cnt_v[1];
            A_PRD_LO: bus_rdata = prd_v[0];
            A_PRD_HI: bus_rdata = prd_v[1];
            A_RUNCTL: begin
                bus_rdata[RC_LO_SH +: 2] = mode_v[0];
                bus_rdata[RC_HI_SH +: 2] = mode_v[1];
            end
            A_GLBCTL: bus_rdata[GC_W-1:0] = gctrl_q;
            default:  bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_addr == cmp_addr(i)) begin
                bus_rdata = cmp_val[i];
            end
        end
    end

    assign irq_lo = irq_v[0];
    assign irq_hi = irq_v[1];

endmodule

// File: rtl/cnt_pair_timer_chk.sv
module cnt_pair_timer_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          run_lo,
    input logic          cnt_lo_we,
    input logic          runctl_we,
    input logic [DW-1:0] cnt_lo,
    input logic [DW-1:0] prd_lo,
    input logic [1:0]    mode_lo,
    input logic          irq_lo,
    input logic          irq_cmp
);

    // R3: a period pulse coincides with the reloaded counter
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (irq_lo && !$past(cnt_lo_we)) |-> (cnt_lo == '0));

    // R4: single-shot returns its field to stopped
    a_r4_once_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_lo && ($past(mode_lo) == 2'b01) && !$past(runctl_we)) |-> (mode_lo == 2'b00));

    // R5: an unreleased half sits at zero and stays silent
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !run_lo |=> ((cnt_lo == '0) && !irq_lo));

    // R6: a running counter advances by one
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (run_lo && (mode_lo == 2'b10) && !cnt_lo_we && !runctl_we && (cnt_lo != prd_lo))
        |=> (cnt_lo == $past(cnt_lo) + 1'b1));

    // R9: no compare pulse unless the low half was counting
    a_r9_cmp_needs_run: assert property (@(posedge clk) disable iff (rst)
        irq_cmp |-> $past(run_lo && ((mode_lo == 2'b01) || (mode_lo == 2'b10))));

endmodule

bind cnt_pair_timer cnt_pair_timer_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_lo    (run_v[0]),
    .cnt_lo_we (stb.cnt_lo),
    .runctl_we (stb.runctl),
    .cnt_lo    (cnt_v[0]),
    .prd_lo    (prd_v[0]),
    .mode_lo   (mode_v[0]),
    .irq_lo    (irq_v[0]),
    .irq_cmp   (irq_cmp)
);

// File: tb/cnt_pair_timer_tb.sv
module cnt_pair_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi, irq_cmp;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_pair_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi),
        .irq_cmp   (irq_cmp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state; R2: unmapped offsets read zero
        foreach (d[i]) begin end
        for (int a = 0; a < 256; a += 4) begin
            rd(8'(a), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
        check("R1 irq_hi", {31'b0, irq_hi}, 32'h0);
        check("R1 irq_cmp", {31'b0, irq_cmp}, 32'h0);

        // R5: halves held while not released
        wr(8'h18, 32'd3);
        wr(8'h20, 32'h0080_0080);
        wr(8'h10, 32'h55);
        rd(8'h10, d); check("R5 write ignored in hold", d, 32'h0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R5 no irq in hold", {31'b0, irq_lo}, 32'h0);
        end
        wr(8'h24, 32'h3);             // released but timer mode 00
        repeat (6) @(negedge clk);
        rd(8'h10, d); check("R5 wrong timer mode holds", d, 32'h0);
        wr(8'h24, 32'h0);
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h5);             // mode 01, low released only
        wr(8'h14, 32'h9);
        rd(8'h14, d); check("R5 high half held", d, 32'h0);
        wr(8'h24, 32'h7);
        rd(8'h24, d); check("R2 global control readback", d, 32'h7);

        // R2: readback and field masking; R9: reserved/stopped modes hold
        wr(8'h1C, 32'hA5A5_5A5A);
        rd(8'h1C, d); check("R2 high period readback", d, 32'hA5A5_5A5A);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); check("R2 run control masked", d, 32'h00C0_00C0);
        wr(8'h10, 32'd7);
        repeat (5) @(negedge clk);
        rd(8'h10, d); check("R9 reserved mode holds", d, 32'd7);
        check("R9 no irq in reserved mode", {31'b0, irq_lo}, 32'h0);
        wr(8'h20, 32'h0);
        repeat (5) @(negedge clk);
        rd(8'h10, d); check("R9 stopped mode holds", d, 32'd7);
        for (int i = 0; i < 8; i++) begin
            wr(8'(8'h60 + 4*i), 32'h1000 + 32'(i));
        end
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h60 + 4*i), d);
            check("R2 compare readback", d, 32'h1000 + 32'(i));
        end

        // R3/R6: repeat-mode sweep on both halves
        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p <= 6; p++) begin
                wr(8'h20, 32'h0);
                wr(h ? 8'h14 : 8'h10, 32'h0);
                wr(h ? 8'h1C : 8'h18, 32'(p));
                wr(8'h20, h ? 32'h0080_0000 : 32'h0000_0080);
                for (int k = 1; k <= 3*(p+1); k++) begin
                    @(negedge clk);
                    check("R3 period pulse", {31'b0, h ? irq_hi : irq_lo},
                          {31'b0, (k % (p+1)) == 0});
                    check("R3 other half silent", {31'b0, h ? irq_lo : irq_hi}, 32'h0);
                    rd(h ? 8'h14 : 8'h10, d);
                    check("R6 counter value", d, 32'(k % (p+1)));
                end
            end
        end

        // R4: single-shot on both halves
        for (int h = 0; h < 2; h++) begin
            for (int p = 1; p <= 4; p++) begin
                wr(8'h20, 32'h0);
                wr(h ? 8'h14 : 8'h10, 32'h0);
                wr(h ? 8'h1C : 8'h18, 32'(p));
                wr(8'h20, h ? 32'h0040_0000 : 32'h0000_0040);
                for (int k = 1; k <= 3*(p+1); k++) begin
                    @(negedge clk);
                    check("R4 single pulse", {31'b0, h ? irq_hi : irq_lo},
                          {31'b0, k == p+1});
                end
                rd(8'h20, d); check("R4 mode cleared", d, 32'h0);
                rd(h ? 8'h14 : 8'h10, d); check("R4 counter parked", d, 32'h0);
            end
        end

        // R7 direct write, R6 wrap
        wr(8'h20, 32'h0);
        wr(8'h18, 32'd3);
        wr(8'h10, 32'hFFFF_FFFE);
        rd(8'h10, d); check("R7 direct counter load", d, 32'hFFFF_FFFE);
        wr(8'h20, 32'h80);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            check("R6 wrap irq timing", {31'b0, irq_lo}, {31'b0, k == 6});
            if (k == 1) begin rd(8'h10, d); check("R6 at top", d, 32'hFFFF_FFFF); end
            if (k == 2) begin rd(8'h10, d); check("R6 wrapped to zero", d, 32'h0); end
        end

        // R8: each compare entry alone; R9: no compare while stopped
        wr(8'h20, 32'h0);
        wr(8'h18, 32'd1000);
        for (int i = 0; i < 8; i++) wr(8'(8'h60 + 4*i), 32'hFFFF_0000);
        for (int i = 0; i < 8; i++) begin
            int v;
            v = 5 + 2*i;
            wr(8'(8'h60 + 4*i), 32'(v));
            wr(8'h20, 32'h0);
            wr(8'h10, 32'h0);
            wr(8'h20, 32'h80);
            for (int k = 1; k <= v+4; k++) begin
                @(negedge clk);
                check("R8 compare pulse", {31'b0, irq_cmp}, {31'b0, k == v+1});
                if (k == v+2) begin
                    rd(8'h10, d);
                    check("R8 counter not reloaded", d, 32'(v+2));
                end
            end
            wr(8'h20, 32'h0);
            rd(8'h10, d);
            wr(8'(8'h60 + 4*i), d);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check("R9 no compare while stopped", {31'b0, irq_cmp}, 32'h0);
            end
            wr(8'(8'h60 + 4*i), 32'hFFFF_0000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule